// File: doc/BRIEF.md
# Two-Level Interrupt Status Controller

This block gathers interrupt events for a USB device function and presents them to a processor through a small register port and a single interrupt line. Protocol logic drives one-cycle event pulses. Each pulse sets a sticky status bit. Device-wide events land in a global source register. Endpoint events land in a status register that belongs to that endpoint. The global register also carries one summary bit per endpoint, and that bit is high while any bit of that endpoint's register is set.

Every status register clears when the processor reads it. A mask register chooses which global bits may drive the interrupt line. The processor handles an interrupt as follows. It reads the global register, which clears the device-wide bits it returns. It then reads the register of each flagged endpoint, which clears that register and therefore its summary bit.

The block has no state machine. It is built from sticky register cells, an address decoder and a registered read multiplexer. The endpoint count may be set from 1 to 16.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, every status register and the mask register hold zero, `irq` is low and `rdata` is zero.
- R2: A pulse on a device-wide event input sets its bit in the global source register at address 0x0C, and the bit stays set until that register is read. The bit positions are: bus reset 16, attach 17, detach 18, resume 19, receive line error 20, token PID checksum error 21.
- R3: A read (`rd_en` high) presents the addressed register's value on `rdata` from the next clock edge. That value is the register contents before the read. `rdata` holds its value until the next read. Reading 0x0C clears the device-wide bits.
- R4: If an event arrives in the same cycle as the clearing read of its register, the bit is set after that cycle. The read returns the value without that event.
- R5: The register of endpoint n sits at 0x40 + 4·n. Its bits are: bit 2 unsupported PID, bit 5 PID sequence error, bit 6 setup packet received. All other bits read as 0. Reading it clears it and leaves every other endpoint unchanged.
- R6: Bit n of the global source register is 1 exactly while the register of endpoint n is non-zero. Reading the global register does not clear it.
- R7: The mask register at 0x08 is writable and readable. Only bits 21:16 and bits NUM_EP-1:0 are kept, and all other bits read as 0. Bit k of the mask enables bit k of the global source register.
- R8: `irq` is high exactly while some global source bit and its mask bit are both 1, including after any change of the mask.
- R9: Events on any number of device-wide and endpoint inputs in the same cycle are all recorded. None is lost.
- R10: A read of any other address returns 0. A write to any address other than 0x08 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_bus_reset | input | 1 | Bus reset detected pulse |
| evt_attach | input | 1 | Device attached pulse |
| evt_detach | input | 1 | Device detached pulse |
| evt_resume | input | 1 | Resume signalling pulse |
| evt_rx_err | input | 1 | Receive line error pulse |
| evt_tok_crc | input | 1 | Token PID checksum error pulse |
| ep_bad_pid | input | NUM_EP | Per-endpoint unsupported PID pulses |
| ep_seq_err | input | NUM_EP | Per-endpoint PID sequence error pulses |
| ep_setup | input | NUM_EP | Per-endpoint setup packet pulses |
| rd_en | input | 1 | Register read strobe (clears on read) |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
Suppose a status bit is lost, or a clear reaches the wrong endpoint. The corruption appears on `irq` in the cycle after the faulty edge, but only if that bit is unmasked. Otherwise it appears on `rdata` one cycle after the next read of that register. The bench therefore compares `rdata` and `irq` with a behavioural model on every clock. It also runs both masked and unmasked phases, so that a wrong internal state cannot stay hidden until the end. The test exercises reads that coincide with events, and reads of the global register while endpoints are pending, because a fault in the clear path shows only then.

// File: rtl/isc_pkg.sv
package isc_pkg;
    localparam int DATA_W   = 32;
    localparam int NUM_DEV  = 6;
    localparam int DEV_LSB  = 16;
    localparam int EP_FLDS  = 3;
    localparam int OFS_MASK = 'h08;
    localparam int OFS_GSRC = 'h0C;
    localparam int OFS_EP0  = 'h40;
    localparam int BIT_BADPID = 2;
    localparam int BIT_SEQERR = 5;
    localparam int BIT_SETUP  = 6;

    function automatic logic [DATA_W-1:0] ep_word(input logic [EP_FLDS-1:0] f);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_BADPID] = f[0];
        w[BIT_SEQERR] = f[1];
        w[BIT_SETUP]  = f[2];
        return w;
    endfunction
endpackage

// File: rtl/isc_sticky_reg.sv
module isc_sticky_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] evt,
    output logic [W-1:0] bits
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits <= '0;
        else        bits <= (clr ? '0 : bits) | evt;
    end

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((bits & $past(evt)) == $past(evt))); // R4
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt == '0) |=> (bits == '0)); // R3
    AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr) |=> ((bits & $past(bits)) == $past(bits))); // R2
endmodule

// File: rtl/isc_decode.sv
module isc_decode
    import isc_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_mask,
    output logic              hit_gsrc,
    output logic [NUM_EP-1:0] hit_ep
);
    assign hit_mask = (addr == ADDR_W'(OFS_MASK));
    assign hit_gsrc = (addr == ADDR_W'(OFS_GSRC));

    for (genvar n = 0; n < NUM_EP; n++) begin : g_ep_hit
        assign hit_ep[n] = (addr == ADDR_W'(OFS_EP0 + 4 * n));
    end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import isc_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_bus_reset,
    input  logic              evt_attach,
    input  logic              evt_detach,
    input  logic              evt_resume,
    input  logic              evt_rx_err,
    input  logic              evt_tok_crc,
    input  logic [NUM_EP-1:0] ep_bad_pid,
    input  logic [NUM_EP-1:0] ep_seq_err,
    input  logic [NUM_EP-1:0] ep_setup,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);
    localparam logic [DATA_W-1:0] IMPL_BITS =
        ((32'd1 << NUM_EP) - 32'd1) | (((32'd1 << NUM_DEV) - 32'd1) << DEV_LSB);

    logic              hit_mask, hit_gsrc;
    logic [NUM_EP-1:0] hit_ep;
    logic [NUM_DEV-1:0] dev_evt, dev_bits;
    logic [NUM_EP-1:0][EP_FLDS-1:0] ep_bits;
    logic [NUM_EP-1:0] ep_sum;
    logic [DATA_W-1:0] gsrc, mask_q, rd_mux;

    isc_decode #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) u_dec (
        .addr(addr), .hit_mask(hit_mask), .hit_gsrc(hit_gsrc), .hit_ep(hit_ep)
    );

    assign dev_evt = {evt_tok_crc, evt_rx_err, evt_resume, evt_detach, evt_attach, evt_bus_reset};

    isc_sticky_reg #(.W(NUM_DEV)) u_dev (
        .clk(clk), .rst_n(rst_n), .clr(rd_en && hit_gsrc), .evt(dev_evt), .bits(dev_bits)
    );

    for (genvar n = 0; n < NUM_EP; n++) begin : g_ep
        isc_sticky_reg #(.W(EP_FLDS)) u_reg (
            .clk(clk), .rst_n(rst_n), .clr(rd_en && hit_ep[n]),
            .evt({ep_setup[n], ep_seq_err[n], ep_bad_pid[n]}), .bits(ep_bits[n])
        );
        assign ep_sum[n] = |ep_bits[n];

        AST_EP_READ_CLEARS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && hit_ep[n] && !ep_setup[n] && !ep_seq_err[n] && !ep_bad_pid[n])
            |=> !ep_sum[n]); // R5
        AST_GSRC_READ_KEEPS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && hit_gsrc && ep_sum[n] && !hit_ep[n]) |=> ep_sum[n]); // R6
    end

    always_comb begin
        gsrc = '0;
        gsrc[NUM_EP-1:0] = ep_sum;
        gsrc[DEV_LSB +: NUM_DEV] = dev_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  mask_q <= '0;
        else if (wr_en && hit_mask)  mask_q <= wdata & IMPL_BITS;
    end

    always_comb begin
        rd_mux = '0;
        if (hit_mask) rd_mux = mask_q;
        if (hit_gsrc) rd_mux = gsrc;
        for (int n = 0; n < NUM_EP; n++) begin
            if (hit_ep[n]) rd_mux = ep_word(ep_bits[n]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_en)  rdata <= rd_mux;
    end

    assign irq = |(gsrc & mask_q);

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_mask) |=> (mask_q == ($past(wdata) & IMPL_BITS))); // R7
    AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq); // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit_mask && !hit_gsrc && hit_ep == '0) |=> (rdata == '0)); // R10
endmodule

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
    localparam int NEP = 4;
    localparam int AW  = 9;
    localparam logic [31:0] IMPL = 32'h003F_000F;

    logic clk = 0, rst_n = 0;
    logic [5:0] dev_e = 0;
    logic [NEP-1:0] bp = 0, sq = 0, su = 0;
    logic rd = 0, wr = 0;
    logic [AW-1:0] a = 0;
    logic [31:0] wd = 0;
    logic [31:0] rdata;
    logic irq;

    int total = 0, bad = 0;
    logic [31:0] dev_m = 0, mask_m = 0, exp_rd = 0;
    logic [31:0] ep_m [NEP];

    always #2 clk = ~clk;

    irq_status_ctrl #(.NUM_EP(NEP), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .evt_bus_reset(dev_e[0]), .evt_attach(dev_e[1]), .evt_detach(dev_e[2]),
        .evt_resume(dev_e[3]), .evt_rx_err(dev_e[4]), .evt_tok_crc(dev_e[5]),
        .ep_bad_pid(bp), .ep_seq_err(sq), .ep_setup(su),
        .rd_en(rd), .wr_en(wr), .addr(a), .wdata(wd), .rdata(rdata), .irq(irq)
    );

    function automatic logic [31:0] gsrc_m();
        logic [31:0] g = dev_m << 16;
        for (int n = 0; n < NEP; n++) if (ep_m[n] != 0) g[n] = 1'b1;
        return g;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [31:0] v;
        if (rd) begin
            v = 0;
            if (a == 9'h08) v = mask_m;
            else if (a == 9'h0C) v = gsrc_m();
            else for (int n = 0; n < NEP; n++) if (a == 9'h40 + 4 * n) v = ep_m[n];
            exp_rd = v;
            if (a == 9'h0C) dev_m = 0;
            for (int n = 0; n < NEP; n++) if (a == 9'h40 + 4 * n) ep_m[n] = 0;
        end
        dev_m = dev_m | 32'(dev_e);
        for (int n = 0; n < NEP; n++)
            ep_m[n] = ep_m[n] | (32'(su[n]) << 6) | (32'(sq[n]) << 5) | (32'(bp[n]) << 2);
        if (wr && a == 9'h08) mask_m = wd & IMPL;
    endtask

    // One clock: inputs set by caller, model updated at the edge, compared at the falling edge.
    task automatic cyc(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check({tag, " rdata"}, rdata, exp_rd);
        check({tag, " irq R8"}, {31'b0, irq}, {31'b0, |(gsrc_m() & mask_m)});
        dev_e = 0; bp = 0; sq = 0; su = 0; rd = 0; wr = 0; a = 0; wd = 0;
    endtask

    task automatic rdreg(input logic [AW-1:0] ad, input string tag);
        rd = 1; a = ad; cyc(tag);
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int n = 0; n < NEP; n++) ep_m[n] = 0;
        repeat (3) @(negedge clk);
        check("R1 rdata reset", rdata, 0);
        check("R1 irq reset", {31'b0, irq}, 0);
        rst_n = 1;
        rdreg(9'h08, "R1 mask");
        rdreg(9'h0C, "R1 gsrc");
        for (int n = 0; n < NEP; n++) rdreg(AW'(9'h40 + 4 * n), "R1 ep");
        // R2 / R3: each device event alone, then read back and clear
        for (int k = 0; k < 6; k++) begin
            dev_e = 6'(1 << k); cyc("R2 event");
            cyc("R2 held");
            rdreg(9'h0C, "R3 read");
            rdreg(9'h0C, "R3 cleared");
        end
        // R7 mask write/readback
        wr = 1; a = 9'h08; wd = 32'hFFFF_FFFF; cyc("R7 write");
        rdreg(9'h08, "R7 readback");
        dev_e = 6'b000100; cyc("R8 irq on");
        // R4: event coincides with clearing read
        dev_e = 6'b000100; rd = 1; a = 9'h0C; cyc("R4 coincide");
        rdreg(9'h0C, "R4 survived");
        // R5 / R6 endpoints
        bp[1] = 1; sq[2] = 1; cyc("R5 set");
        su[2] = 1; cyc("R5 setup");
        rdreg(9'h0C, "R6 summary");
        rdreg(9'h0C, "R6 not cleared");
        rdreg(9'h44, "R5 ep1");
        rdreg(9'h0C, "R5 ep2 kept");
        rdreg(9'h48, "R5 ep2");
        sq[3] = 1; rd = 1; a = 9'h4C; cyc("R4 ep coincide");
        rdreg(9'h4C, "R4 ep survived");
        // R9 everything at once
        dev_e = 6'h3F; bp = '1; sq = '1; su = '1; cyc("R9 all");
        rdreg(9'h0C, "R9 gsrc");
        for (int n = 0; n < NEP; n++) rdreg(AW'(9'h40 + 4 * n), "R9 ep");
        // R10 unmapped
        rdreg(9'h20, "R10 unmapped read");
        wr = 1; a = 9'h0C; wd = 32'hFFFF_FFFF; cyc("R10 write gsrc");
        wr = 1; a = 9'h40; wd = 32'hFFFF_FFFF; cyc("R10 write ep");
        rdreg(9'h0C, "R10 gsrc after");
        rdreg(9'h40, "R10 ep after");
        rdreg(9'h08, "R10 mask kept");
        // R8 narrow mask
        wr = 1; a = 9'h08; wd = 32'h0002_0000; cyc("R7 narrow");
        dev_e = 6'b000001; cyc("R8 masked src");
        dev_e = 6'b000010; cyc("R8 enabled src");
        wr = 1; a = 9'h08; wd = 0; cyc("R8 mask off");
        rdreg(9'h0C, "R3 drain");
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = $urandom;
            logic [31:0] s = $urandom;
            dev_e = r[5:0] & r[11:6];
            bp = NEP'(r[15:12] & s[3:0]);
            sq = NEP'(r[19:16] & s[7:4]);
            su = NEP'(r[23:20] & s[11:8]);
            rd = r[24];
            case (s[14:12])
                3'd0: a = 9'h08;
                3'd1, 3'd2: a = 9'h0C;
                3'd7: a = 9'h30;
                default: a = AW'(9'h40 + 4 * s[17:16]);
            endcase
            wr = (s[22:20] == 0);
            if (wr) a = 9'h08;
            wd = $urandom;
            cyc("R9 mixed");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule